// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Guard

This block guards one memory data word with Hamming check bits and one overall parity bit. On the write side, a purely combinational encoder takes the data word. It returns the check bits and the parity bit that are stored alongside the data.

On the read side, the stored data, check bits and parity bit enter through a valid/ready stream. The data check bits are recomputed and XORed with the stored ones to form a syndrome. A separate total-parity test then decides what kind of error is present:

- a single data-bit error is repaired;
- a lone check-bit or parity-bit error is flagged;
- two-bit errors and syndromes that point outside the codeword are reported as uncorrectable, and the data is left untouched.

The decoded result leaves through a second valid/ready stream. With `REG_OUT=1` (the default) a one-entry output register sits between the streams:

- an accepted read word appears at the output one clock later;
- the output holds its valid, data and flags unchanged while `dec_ready_i` is low;
- `rd_ready_o` is high whenever the register is empty or is being drained in the same cycle.

With `REG_OUT=0` the decoder is a combinational path, and valid and ready pass straight through.

Top module: `secded_ecc_unit`

## Requirements
- R1: With 8 data bits the block uses 4 check bits (the smallest K with 2^K-1 >= 8+K). Codeword position 2^i holds check port bit i, so `enc_check_o[3:0]` carries positions 8,4,2,1 from MSB to LSB. Data bit j (bit 0 is the LSB) sits at the (j+1)-th position from 1 to 12 that is not a power of two: positions 3,5,6,7,9,10,11,12 in order.
- R2: Each check bit is the XOR of the data bits whose codeword positions have bit i set, so `enc_check_o` for data 0x39 is 4'b0111.
- R3: `enc_par_o` makes the count of ones over the 8 data bits, the 4 check bits and the parity bit even.
- R4: A zero syndrome with matching parity passes the data unchanged, raises no flag and gives `dec_pos_o`=0.
- R5: A nonzero syndrome that is not one-hot and not above 12, with mismatched parity, inverts the data bit at that position and raises only `dec_fixed_o`. `dec_pos_o` equals the syndrome.
- R6: A one-hot syndrome with mismatched parity leaves the data unchanged and raises only `dec_chkerr_o`. `dec_pos_o` gives the failing check position.
- R7: A zero syndrome with mismatched parity leaves the data unchanged and raises only `dec_parerr_o`.
- R8: A nonzero syndrome with matching parity (two errors) raises only `dec_uncorr_o` and outputs the read data as received. `dec_pos_o` equals the syndrome.
- R9: A syndrome of 13 to 15 with mismatched parity raises only `dec_uncorr_o` and leaves the data as received.
- R10: Data 0x39 stored with check bits 0111 and read back with bit 5 (position 10) inverted gives syndrome 1010, and the output is 0x39 with `dec_fixed_o` set.
- R11: Stream rules with `REG_OUT=1`:
  - `dec_valid_o` rises the cycle after an accepted read word;
  - while `dec_valid_o` is high and `dec_ready_i` is low, the output stays valid with unchanged data and flags;
  - `rd_ready_o` equals not-full OR `dec_ready_i`.
- R12: After reset `dec_valid_o` is low and `rd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 8 | Data word to encode |
| enc_check_o | output | 4 | Check bits to store |
| enc_par_o | output | 1 | Overall parity bit to store |
| rd_valid_i | input | 1 | Read word valid |
| rd_ready_o | output | 1 | Read word accepted when high with valid |
| rd_data_i | input | 8 | Stored data as read |
| rd_check_i | input | 4 | Stored check bits as read |
| rd_par_i | input | 1 | Stored parity bit as read |
| dec_valid_o | output | 1 | Decoded result valid |
| dec_ready_i | input | 1 | Consumer ready |
| dec_data_o | output | 8 | Data after correction |
| dec_pos_o | output | 4 | Syndrome, the codeword position of the error |
| dec_fixed_o | output | 1 | Single data-bit error corrected |
| dec_chkerr_o | output | 1 | Single check-bit error |
| dec_parerr_o | output | 1 | Overall parity bit alone in error |
| dec_uncorr_o | output | 1 | Uncorrectable error |

## Verification
A wrong check-bit mask shows up on `enc_check_o` for any data word that touches the affected bit. On the read path, the same fault makes one class of single errors land at the wrong position or be repaired in the wrong bit, and this appears at the output one cycle after that word is accepted. A stuck or mis-updated full flag in the output register shows up on the very next clock in one of two ways: `dec_valid_o` disagrees with the count of words accepted but not yet consumed, or `rd_ready_o` drops while the register is empty. A payload register that loads while stalled changes `dec_data_o` during back-pressure, which shows within the stalled cycles.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [2:0] {
    K_CLEAN  = 3'd0,
    K_FIXED  = 3'd1,
    K_CHECK  = 3'd2,
    K_PARITY = 3'd3,
    K_UNCORR = 3'd4
  } dec_kind_e;

  // smallest k such that 2^k - 1 >= m + k
  function automatic int check_width(input int m);
    int k;
    k = 1;
    while (((1 << k) - 1) < (m + k)) k++;
    return k;
  endfunction

  // codeword position of data bit j (0-based): j-th non-power-of-two from 3
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // data bits covered by check bit i
  function automatic logic [63:0] cover_mask(input int i, input int m);
    logic [63:0] r;
    r = '0;
    for (int j = 0; j < m && j < 64; j++) begin
      if (((data_pos(j) >> i) & 1) == 1) r[j] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/secded_checkgen.sv
module secded_checkgen
  import secded_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHECK_W = check_width(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [CHECK_W-1:0] check_o
);

  for (genvar i = 0; i < CHECK_W; i++) begin : g_chk
    localparam logic [63:0] MASK = cover_mask(i, DATA_W);
    assign check_o[i] = ^(data_i & MASK[DATA_W-1:0]);
  end

endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHECK_W = check_width(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [CHECK_W-1:0] check_i,
  input  logic               par_i,
  input  logic [CHECK_W-1:0] calc_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [CHECK_W-1:0] pos_o,
  output dec_kind_e          kind_o
);

  localparam int LAST_POS = DATA_W + CHECK_W;

  logic [CHECK_W-1:0] syn;
  logic               par_err;
  logic               syn_zero;
  logic               syn_hot;
  logic               syn_far;
  logic [DATA_W-1:0]  flip;

  assign syn      = check_i ^ calc_i;
  assign par_err  = ^{data_i, check_i, par_i};
  assign syn_zero = (syn == '0);
  assign syn_hot  = ($countones(syn) == 1);
  assign syn_far  = (int'(syn) > LAST_POS);

  for (genvar j = 0; j < DATA_W; j++) begin : g_flip
    localparam int POS = data_pos(j);
    assign flip[j] = (int'(syn) == POS);
  end

  always_comb begin
    if (syn_zero) kind_o = par_err ? K_PARITY : K_CLEAN;
    else if (!par_err) kind_o = K_UNCORR;
    else if (syn_hot) kind_o = K_CHECK;
    else if (syn_far) kind_o = K_UNCORR;
    else kind_o = K_FIXED;
  end

  assign data_o = (kind_o == K_FIXED) ? (data_i ^ flip) : data_i;
  assign pos_o  = syn;

  always_comb begin
    if (kind_o == K_FIXED) begin
      assert_fix_one_bit_R5: assert ($countones(data_o ^ data_i) == 1);
    end
    if (kind_o == K_UNCORR) begin
      assert_uncorr_keeps_R8: assert (data_o == data_i);
    end
  end

endmodule

// File: rtl/secded_outreg.sv
module secded_outreg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);

  if (REG_OUT) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign ready_o = !full_q || ready_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (ready_o) begin
        full_q <= valid_i;
        if (valid_i) data_q <= data_i;
      end
    end

    assign valid_o = full_q;
    assign data_o  = data_q;

    assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && !ready_i |=> valid_o && $stable(data_o));
    assert_take_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && ready_o |=> valid_o);
    assert_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && ready_i && !valid_i |=> !valid_o);
  end else begin : g_pass
    assign ready_o = ready_i;
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end

endmodule

// File: rtl/secded_ecc_unit.sv
module secded_ecc_unit
  import secded_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int CHECK_W = check_width(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  enc_data_i,
  output logic [CHECK_W-1:0] enc_check_o,
  output logic               enc_par_o,
  input  logic               rd_valid_i,
  output logic               rd_ready_o,
  input  logic [DATA_W-1:0]  rd_data_i,
  input  logic [CHECK_W-1:0] rd_check_i,
  input  logic               rd_par_i,
  output logic               dec_valid_o,
  input  logic               dec_ready_i,
  output logic [DATA_W-1:0]  dec_data_o,
  output logic [CHECK_W-1:0] dec_pos_o,
  output logic               dec_fixed_o,
  output logic               dec_chkerr_o,
  output logic               dec_parerr_o,
  output logic               dec_uncorr_o
);

  localparam int PAY_W = DATA_W + CHECK_W + 4;

  // write side
  secded_checkgen #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_enc (
    .data_i (enc_data_i),
    .check_o(enc_check_o)
  );
  assign enc_par_o = ^{enc_data_i, enc_check_o};

  // read side
  logic [CHECK_W-1:0] rd_calc;
  logic [DATA_W-1:0]  fx_data;
  logic [CHECK_W-1:0] fx_pos;
  dec_kind_e          fx_kind;
  logic [3:0]         fx_flags;
  logic [PAY_W-1:0]   pay_in;
  logic [PAY_W-1:0]   pay_out;

  secded_checkgen #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_rdchk (
    .data_i (rd_data_i),
    .check_o(rd_calc)
  );

  secded_fix #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_fix (
    .data_i (rd_data_i),
    .check_i(rd_check_i),
    .par_i  (rd_par_i),
    .calc_i (rd_calc),
    .data_o (fx_data),
    .pos_o  (fx_pos),
    .kind_o (fx_kind)
  );

  assign fx_flags = {fx_kind == K_FIXED, fx_kind == K_CHECK,
                     fx_kind == K_PARITY, fx_kind == K_UNCORR};
  assign pay_in   = {fx_data, fx_pos, fx_flags};

  secded_outreg #(.W(PAY_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rd_valid_i),
    .ready_o(rd_ready_o),
    .data_i (pay_in),
    .valid_o(dec_valid_o),
    .ready_i(dec_ready_i),
    .data_o (pay_out)
  );

  assign {dec_data_o, dec_pos_o, dec_fixed_o, dec_chkerr_o,
          dec_parerr_o, dec_uncorr_o} = pay_out;

  assert_fixed_has_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_fixed_o |-> dec_pos_o != '0);
  assert_chk_onehot_pos_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_chkerr_o |-> $onehot0(dec_pos_o) && dec_pos_o != '0);
  assert_parity_zero_pos_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_parerr_o |-> dec_pos_o == '0);

endmodule

// File: tb/test_secded_ecc_unit.sv
module test_secded_ecc_unit;

  typedef struct {
    logic [7:0] data;
    logic [3:0] chk;
    logic       par;
    logic [7:0] xdata;
    logic [3:0] xpos;
    logic [3:0] xflags;  // {fixed, chkerr, parerr, uncorr}
    string      req;
  } vec_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] enc_data = '0;
  logic [3:0] enc_check;
  logic       enc_par;
  logic       rd_valid = 1'b0;
  logic       rd_ready;
  logic [7:0] rd_data = '0;
  logic [3:0] rd_check = '0;
  logic       rd_par = 1'b0;
  logic       dec_valid;
  logic       dec_ready = 1'b0;
  logic [7:0] dec_data;
  logic [3:0] dec_pos;
  logic       f_fix, f_chk, f_par, f_unc;

  int checks = 0;
  int errors = 0;
  vec_t vecs[$];
  vec_t q[$];

  always #5 clk = ~clk;

  secded_ecc_unit i_secded_ecc_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_data_i(enc_data), .enc_check_o(enc_check), .enc_par_o(enc_par),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_data_i(rd_data),
    .rd_check_i(rd_check), .rd_par_i(rd_par),
    .dec_valid_o(dec_valid), .dec_ready_i(dec_ready), .dec_data_o(dec_data),
    .dec_pos_o(dec_pos), .dec_fixed_o(f_fix), .dec_chkerr_o(f_chk),
    .dec_parerr_o(f_par), .dec_uncorr_o(f_unc)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // reference codeword: index = position, index 0 = overall parity
  function automatic logic [12:0] ref_encode(logic [7:0] d);
    logic [12:0] cw;
    int j;
    cw = '0;
    j = 0;
    for (int p = 1; p <= 12; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[j];
        j++;
      end
    end
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = 1'b0;
      for (int p = 1; p <= 12; p++)
        if ((p & (p - 1)) != 0 && ((p >> i) & 1) == 1) b ^= cw[p];
      cw[1 << i] = b;
    end
    cw[0] = ^cw[12:1];
    return cw;
  endfunction

  function automatic logic [7:0] data_of(logic [12:0] cw);
    return {cw[12], cw[11], cw[10], cw[9], cw[7], cw[6], cw[5], cw[3]};
  endfunction

  function automatic logic [3:0] check_of(logic [12:0] cw);
    return {cw[8], cw[4], cw[2], cw[1]};
  endfunction

  task automatic add_vec(logic [7:0] d, int pa, int pb, int pc, string req);
    logic [12:0] cw;
    vec_t v;
    int n;
    int x;
    int ps[3];
    cw = ref_encode(d);
    ps[0] = pa; ps[1] = pb; ps[2] = pc;
    n = 0; x = 0;
    foreach (ps[k]) if (ps[k] >= 0) begin
      cw[ps[k]] = ~cw[ps[k]];
      n++;
      x ^= ps[k];
    end
    v.data = data_of(cw);
    v.chk  = check_of(cw);
    v.par  = cw[0];
    v.xpos = x[3:0];
    v.req  = req;
    if (n == 0) begin
      v.xdata = d; v.xflags = 4'b0000;
    end else if (n == 1) begin
      v.xdata = d;
      if (pa == 0) v.xflags = 4'b0010;
      else if ((pa & (pa - 1)) == 0) v.xflags = 4'b0100;
      else v.xflags = 4'b1000;
    end else begin
      v.xdata = v.data; v.xflags = 4'b0001;
    end
    vecs.push_back(v);
  endtask

  initial begin
    int idx;
    int cycles;
    logic [12:0] cw;

    // encoder, combinational
    enc_data = 8'h39;
    #1;
    chk("R1/R2 example check bits", 32'(enc_check), 32'h7);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      d = (k < 2) ? {8{k[0]}} : 8'($urandom);
      enc_data = d;
      #1;
      cw = ref_encode(d);
      chk("R2 check bits", 32'(enc_check), 32'(check_of(cw)));
      chk("R3 overall parity", 32'(enc_par), 32'(cw[0]));
    end

    // decode vectors
    add_vec(8'h39, 10, -1, -1, "R10 example position 10");
    for (int p = 0; p <= 12; p++)
      add_vec(8'hA5, p, -1, -1,
              p == 0 ? "R7 parity bit" : ((p & (p - 1)) == 0 ? "R6 check bit" : "R5 data bit"));
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      int a;
      int b;
      d = 8'($urandom);
      a = int'($urandom % 13);
      b = int'(($urandom % 12) + 1);
      if (b == a) b = (a % 12) + 1;
      add_vec(d, -1, -1, -1, "R4 clean");
      add_vec(d, a, -1, -1,
              a == 0 ? "R7 parity bit" : ((a & (a - 1)) == 0 ? "R6 check bit" : "R5 data bit"));
      add_vec(d, a, b, -1, "R8 double");
    end
    add_vec(8'h5C, 1, 4, 8, "R9 syndrome 13");
    add_vec(8'h5C, 2, 4, 8, "R9 syndrome 14");
    add_vec(8'h5C, 3, 4, 8, "R9 syndrome 15");
    add_vec(8'hFF, 3, 4, 8, "R9 syndrome 15 ones");

    // reset
    repeat (3) @(negedge clk);
    chk("R12 valid after reset", 32'(dec_valid), 32'h0);
    chk("R12 ready after reset", 32'(rd_ready), 32'h1);
    rst_n = 1'b1;

    idx = 0;
    cycles = 0;
    while ((idx < vecs.size() || q.size() != 0) && cycles < 50000) begin
      @(negedge clk);
      cycles++;
      chk("R11 valid tracks pending", 32'(dec_valid), 32'(q.size() != 0));
      if (dec_valid && q.size() != 0)
        chk(q[0].req, {12'h0, dec_data, dec_pos, f_fix, f_chk, f_par, f_unc},
            {12'h0, q[0].xdata, q[0].xpos, q[0].xflags});
      dec_ready = ($urandom % 4) != 0;
      if (idx < vecs.size() && ($urandom % 4) != 0) begin
        rd_valid = 1'b1;
        rd_data  = vecs[idx].data;
        rd_check = vecs[idx].chk;
        rd_par   = vecs[idx].par;
      end else begin
        rd_valid = 1'b0;
      end
      #1;
      chk("R11 ready rule", 32'(rd_ready), 32'(q.size() == 0 || dec_ready));
      if (dec_valid && dec_ready) void'(q.pop_front());
      if (rd_valid && rd_ready) begin
        q.push_back(vecs[idx]);
        idx++;
      end
    end
    if (cycles >= 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11 got %0d exp %0d", idx, vecs.size());
    end
    rd_valid = 1'b0;
    @(negedge clk);
    chk("R11 empty after drain", 32'(dec_valid), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule